// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block collects eleven interrupt sources for a processor core and presents one of them at a time. The source with the highest fixed priority that is pending, enabled by the mask register and permitted by the current service state is shown with its source index and its vector address. Internal requests are single-cycle pulses that set a pending latch. The three active-low external pins are each sampled once and are then either latched on a falling edge or used as a level request. The core acknowledges the presented request, which clears its edge latch and records it as in service. The core later signals a return, which retires the in-service request.

A small gate state machine decides whether anything may be taken at all. It has three states. GATE_OPEN is normal operation. GATE_SETTLE is the single cycle that follows a mask write. GATE_SHUT holds from a global disable until the next global enable. Its transitions are:
- open→settle on a mask write;
- settle→open when no further write arrives;
- settle→settle on a repeated write;
- any state→shut on a disable strobe;
- shut→open on an enable strobe;
- shut→settle on an enable strobe together with a mask write.

A service tracker implements nested or sequential servicing. It keeps a status-stack depth counter with an empty flag and a sticky overflow flag.

Top module: `irqc_top`

## Requirements
- R1: Sources in descending priority, with their index and vector:
  - index 0: powerdown, vector 0x002C
  - index 1: external pin 2, vector 0x0004
  - index 2: host write, vector 0x0008
  - index 3: host read, vector 0x000C
  - index 4: serial port 0 transmit, vector 0x0010
  - index 5: serial port 0 receive, vector 0x0014
  - index 6: software 1, vector 0x0018
  - index 7: software 0, vector 0x001C
  - index 8: serial port 1 transmit or external pin 1, vector 0x0020
  - index 9: serial port 1 receive or external pin 0, vector 0x0024
  - index 10: timer, vector 0x0028

  `irq_idx` and `irq_vec` show the highest-priority eligible source, and `irq_vec` is 0 when `irq_valid` is low. A pulse or software set that arrives in one cycle is visible after the next clock edge.
- R2: Bit k of the mask register enables source k for k from 1 to 10. The powerdown source (index 0) ignores the mask, and mask bit 0 has no effect on any source.
- R3: After reset the following hold: the mask is all zero; global servicing is enabled; all external pins are level-sensitive; sequential mode is selected; nothing is pending; `depth` is 0; `stk_empty` is 1; `stk_ovf` is 0; and `irq_valid` is 0.
- R4: When control bit k is 1, a falling edge on `ext_n[k]` sets a pending latch, which is visible two clock edges after the pin falls. The latch stays set after the pin returns high.
- R5: When control bit k is 0, `ext_n[k]` requests while it is low, visible one edge after the pin falls. It is not latched, so an acknowledge does not remove it and releasing the pin does.
- R6: In the cycle after a mask write, `irq_valid` is 0.
- R7: A global disable blocks every source, including powerdown, until a global enable. Pending requests are kept.
- R8: On a force/clear write, `fc_set` bits set pending latches and `fc_clr` bits clear them. When both bits are set for the same source, the clear wins.
- R9: `ack` while `irq_valid` is high clears the latch of the presented source, marks it in service and increments `depth`.
- R10: With control bit 3 set to 1 (nested mode), only sources of strictly higher priority than every in-service source may be presented. `rti` retires the highest-priority in-service source.
- R11: With control bit 3 set to 0 (sequential mode), nothing is presented while any source is in service, until `rti`.
- R12: `depth` counts acknowledges minus returns and saturates at STACK_DEPTH. An acknowledge at full depth sets `stk_ovf`, which stays set until reset. `stk_empty` is 1 exactly when `depth` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ext_n | input | 3 | Active-low external interrupt pins |
| pwd_req | input | 1 | Powerdown request pulse |
| host_wr_req | input | 1 | Host write request pulse |
| host_rd_req | input | 1 | Host read request pulse |
| sp0_tx_req | input | 1 | Serial port 0 transmit pulse |
| sp0_rx_req | input | 1 | Serial port 0 receive pulse |
| sp1_tx_req | input | 1 | Serial port 1 transmit pulse |
| sp1_rx_req | input | 1 | Serial port 1 receive pulse |
| tmr_req | input | 1 | Timer request pulse |
| mask_wr | input | 1 | Mask register write strobe |
| mask_data | input | 11 | Mask value, bit k for source k |
| ctl_wr | input | 1 | Control register write strobe |
| ctl_data | input | 4 | Bits 2..0 select edge mode for each pin; bit 3 selects nested mode |
| fc_wr | input | 1 | Force/clear write strobe |
| fc_set | input | 11 | Pending bits to force |
| fc_clr | input | 11 | Pending bits to clear |
| gie_on | input | 1 | Global enable strobe |
| gie_off | input | 1 | Global disable strobe |
| ack | input | 1 | Core accepts the presented request |
| rti | input | 1 | Core returns from the current service routine |
| irq_valid | output | 1 | A request is presented |
| irq_idx | output | 4 | Index of the presented source |
| irq_vec | output | 14 | Vector address of the presented source |
| depth | output | DEPTH_W | Status stack depth |
| stk_empty | output | 1 | Depth is zero |
| stk_ovf | output | 1 | Sticky overflow flag |

## Verification
The overflow flag is the hardest state to reach. Nesting is only possible toward strictly higher priorities, so at the default depth of twelve there are not enough distinct sources to overflow the stack. The bench therefore builds the block with a depth of four. In nested mode it forces and acknowledges five software-set requests in rising priority order, which pushes past full; it then returns five times to show that the flag stays set while the depth drains to zero. Nested retirement order is reached in a similar way: one lower-priority request is left pending beneath two in-service ones, and the bench watches when it becomes visible.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
    localparam int NSRC       = 11;
    localparam int NEXT       = 3;
    localparam int IDX_W      = $clog2(NSRC);
    localparam int VEC_W      = 14;
    localparam int VEC_STRIDE = 4;
    localparam int CTL_W      = NEXT + 1;

    // source indices, index 0 has the highest priority
    localparam int SRC_PWD  = 0;
    localparam int SRC_EXT2 = 1;
    localparam int SRC_HWR  = 2;
    localparam int SRC_HRD  = 3;
    localparam int SRC_S0TX = 4;
    localparam int SRC_S0RX = 5;
    localparam int SRC_SW1  = 6;
    localparam int SRC_SW0  = 7;
    localparam int SRC_S1TX = 8;
    localparam int SRC_S1RX = 9;
    localparam int SRC_TMR  = 10;

    typedef enum logic [1:0] {
        GATE_OPEN   = 2'd0,
        GATE_SETTLE = 2'd1,
        GATE_SHUT   = 2'd2
    } gate_state_e;

    // powerdown sits above every other vector slot
    function automatic logic [VEC_W-1:0] vector_of(input logic [IDX_W-1:0] idx);
        if (idx == IDX_W'(SRC_PWD))
            return VEC_W'(NSRC * VEC_STRIDE);
        return VEC_W'(int'(idx) * VEC_STRIDE);
    endfunction
endpackage

// File: rtl/irqc_pin_sense.sv
module irqc_pin_sense #(
    parameter int NPIN = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NPIN-1:0] pin_n,
    input  logic [NPIN-1:0] edge_sel,
    output logic [NPIN-1:0] fall_ev,
    output logic [NPIN-1:0] lvl_req
);
    logic [NPIN-1:0] pin_q;
    logic [NPIN-1:0] pin_qq;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pin_q  <= '1;
            pin_qq <= '1;
        end else begin
            pin_q  <= pin_n;
            pin_qq <= pin_q;
        end
    end

    for (genvar p = 0; p < NPIN; p++) begin : g_pin
        assign fall_ev[p] = edge_sel[p] & pin_qq[p] & ~pin_q[p];
        assign lvl_req[p] = ~edge_sel[p] & ~pin_q[p];
    end
endmodule

// File: rtl/irqc_src_latch.sv
module irqc_src_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic set_ev,
    input  logic sw_set,
    input  logic sw_clr,
    input  logic ack_hit,
    output logic pend
);
    // software clear beats everything, a fresh event beats the acknowledge
    always_ff @(posedge clk) begin
        if (!rst_n)
            pend <= 1'b0;
        else if (sw_clr)
            pend <= 1'b0;
        else if (set_ev || sw_set)
            pend <= 1'b1;
        else if (ack_hit)
            pend <= 1'b0;
    end
endmodule

// File: rtl/irqc_gate_fsm.sv
module irqc_gate_fsm
    import irqc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic mask_wr,
    input  logic gie_on,
    input  logic gie_off,
    output logic gate_open
);
    gate_state_e state_q;
    gate_state_e state_d;

    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= GATE_OPEN;
        else
            state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            GATE_OPEN: begin
                if (gie_off)      state_d = GATE_SHUT;
                else if (mask_wr) state_d = GATE_SETTLE;
            end
            GATE_SETTLE: begin
                if (gie_off)      state_d = GATE_SHUT;
                else if (mask_wr) state_d = GATE_SETTLE;
                else              state_d = GATE_OPEN;
            end
            GATE_SHUT: begin
                if (gie_off)      state_d = GATE_SHUT;
                else if (gie_on)  state_d = mask_wr ? GATE_SETTLE : GATE_OPEN;
            end
            default:              state_d = GATE_SHUT;
        endcase
    end

    always_comb begin
        gate_open = (state_q == GATE_OPEN);
    end
endmodule

// File: rtl/irqc_nest_track.sv
module irqc_nest_track
    import irqc_pkg::*;
#(
    parameter int STACK_DEPTH = 12,
    parameter int DEPTH_W     = $clog2(STACK_DEPTH + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               push,
    input  logic               pop,
    input  logic [IDX_W-1:0]   push_idx,
    input  logic               nest_mode,
    output logic [NSRC-1:0]    allow,
    output logic [DEPTH_W-1:0] depth,
    output logic               empty,
    output logic               ovf
);
    localparam logic [DEPTH_W-1:0] FULL = DEPTH_W'(STACK_DEPTH);

    logic [NSRC-1:0] active_q;
    logic [NSRC-1:0] active_d;
    logic [NSRC-1:0] allow_nest;
    logic            seen;

    always_comb begin
        active_d = active_q;
        if (pop)
            active_d = active_d & (active_d - NSRC'(1));
        if (push)
            active_d = active_d | (NSRC'(1) << push_idx);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_q <= '0;
            depth    <= '0;
            ovf      <= 1'b0;
        end else begin
            active_q <= active_d;
            if (push && !pop) begin
                if (depth == FULL) ovf <= 1'b1;
                else               depth <= depth + DEPTH_W'(1);
            end else if (pop && !push && depth != '0) begin
                depth <= depth - DEPTH_W'(1);
            end
        end
    end

    // nested: a source is allowed only above every in-service one
    always_comb begin
        seen = 1'b0;
        for (int i = 0; i < NSRC; i++) begin
            seen          = seen | active_q[i];
            allow_nest[i] = ~seen;
        end
    end

    assign allow = nest_mode ? allow_nest : {NSRC{~|active_q}};
    assign empty = (depth == '0);
endmodule

// File: rtl/irqc_prio_pick.sv
module irqc_prio_pick
    import irqc_pkg::*;
(
    input  logic [NSRC-1:0]  req,
    output logic             valid,
    output logic [IDX_W-1:0] idx
);
    always_comb begin
        valid = 1'b0;
        idx   = '0;
        for (int i = NSRC - 1; i >= 0; i--) begin
            if (req[i]) begin
                valid = 1'b1;
                idx   = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/irqc_top.sv
module irqc_top
    import irqc_pkg::*;
#(
    parameter  int STACK_DEPTH = 12,
    localparam int DEPTH_W     = $clog2(STACK_DEPTH + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [2:0]         ext_n,
    input  logic               pwd_req,
    input  logic               host_wr_req,
    input  logic               host_rd_req,
    input  logic               sp0_tx_req,
    input  logic               sp0_rx_req,
    input  logic               sp1_tx_req,
    input  logic               sp1_rx_req,
    input  logic               tmr_req,
    input  logic               mask_wr,
    input  logic [10:0]        mask_data,
    input  logic               ctl_wr,
    input  logic [3:0]         ctl_data,
    input  logic               fc_wr,
    input  logic [10:0]        fc_set,
    input  logic [10:0]        fc_clr,
    input  logic               gie_on,
    input  logic               gie_off,
    input  logic               ack,
    input  logic               rti,
    output logic               irq_valid,
    output logic [3:0]         irq_idx,
    output logic [13:0]        irq_vec,
    output logic [DEPTH_W-1:0] depth,
    output logic               stk_empty,
    output logic               stk_ovf
);
    logic [NSRC-1:0] mask_q;
    logic [NEXT-1:0] edge_q;
    logic            nest_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q <= '0;
            edge_q <= '0;
            nest_q <= 1'b0;
        end else begin
            if (mask_wr) mask_q <= mask_data;
            if (ctl_wr) begin
                edge_q <= ctl_data[NEXT-1:0];
                nest_q <= ctl_data[NEXT];
            end
        end
    end

    logic [NEXT-1:0] fall_ev;
    logic [NEXT-1:0] lvl_req;

    irqc_pin_sense #(.NPIN(NEXT)) u_pins (
        .clk      (clk),
        .rst_n    (rst_n),
        .pin_n    (ext_n),
        .edge_sel (edge_q),
        .fall_ev  (fall_ev),
        .lvl_req  (lvl_req)
    );

    logic [NSRC-1:0] set_ev;
    logic [NSRC-1:0] lvl_vec;

    always_comb begin
        set_ev           = '0;
        set_ev[SRC_PWD]  = pwd_req;
        set_ev[SRC_EXT2] = fall_ev[2];
        set_ev[SRC_HWR]  = host_wr_req;
        set_ev[SRC_HRD]  = host_rd_req;
        set_ev[SRC_S0TX] = sp0_tx_req;
        set_ev[SRC_S0RX] = sp0_rx_req;
        set_ev[SRC_S1TX] = sp1_tx_req | fall_ev[1];
        set_ev[SRC_S1RX] = sp1_rx_req | fall_ev[0];
        set_ev[SRC_TMR]  = tmr_req;
        lvl_vec           = '0;
        lvl_vec[SRC_EXT2] = lvl_req[2];
        lvl_vec[SRC_S1TX] = lvl_req[1];
        lvl_vec[SRC_S1RX] = lvl_req[0];
    end

    logic [NSRC-1:0]  pend;
    logic [NSRC-1:0]  ack_hit;
    logic             pick_valid;
    logic [IDX_W-1:0] pick_idx;
    logic             take;

    assign take = ack & pick_valid;

    for (genvar s = 0; s < NSRC; s++) begin : g_src
        assign ack_hit[s] = take & (pick_idx == IDX_W'(s));
        irqc_src_latch u_latch (
            .clk     (clk),
            .rst_n   (rst_n),
            .set_ev  (set_ev[s]),
            .sw_set  (fc_wr & fc_set[s]),
            .sw_clr  (fc_wr & fc_clr[s]),
            .ack_hit (ack_hit[s]),
            .pend    (pend[s])
        );
    end

    logic gate_open;

    irqc_gate_fsm u_gate (
        .clk       (clk),
        .rst_n     (rst_n),
        .mask_wr   (mask_wr),
        .gie_on    (gie_on),
        .gie_off   (gie_off),
        .gate_open (gate_open)
    );

    logic [NSRC-1:0] allow;

    irqc_nest_track #(
        .STACK_DEPTH (STACK_DEPTH),
        .DEPTH_W     (DEPTH_W)
    ) u_nest (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (take),
        .pop       (rti),
        .push_idx  (pick_idx),
        .nest_mode (nest_q),
        .allow     (allow),
        .depth     (depth),
        .empty     (stk_empty),
        .ovf       (stk_ovf)
    );

    logic [NSRC-1:0] elig;

    assign elig = (pend | lvl_vec)
                & (mask_q | (NSRC'(1) << SRC_PWD))
                & allow
                & {NSRC{gate_open}};

    irqc_prio_pick u_pick (
        .req   (elig),
        .valid (pick_valid),
        .idx   (pick_idx)
    );

    assign irq_valid = pick_valid;
    assign irq_idx   = pick_idx;
    assign irq_vec   = pick_valid ? vector_of(pick_idx) : '0;
endmodule

// File: rtl/irqc_checker.sv
module irqc_checker #(
    parameter int STACK_DEPTH = 12,
    parameter int DEPTH_W     = 4
) (
    input logic               clk,
    input logic               rst_n,
    input logic               mask_wr,
    input logic               gie_off,
    input logic               ack,
    input logic               rti,
    input logic               nest_q,
    input logic [10:0]        mask_q,
    input logic               irq_valid,
    input logic [3:0]         irq_idx,
    input logic [13:0]        irq_vec,
    input logic [DEPTH_W-1:0] depth,
    input logic               stk_empty,
    input logic               stk_ovf
);
    a_r1_pwd_vector: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_valid && irq_idx == 4'd0) |-> irq_vec == 14'h002C);

    a_r2_mask_honoured: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_valid && irq_idx != 4'd0) |-> mask_q[irq_idx]);

    a_r6_settle_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        mask_wr |=> !irq_valid);

    a_r7_shut_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        gie_off |=> !irq_valid);

    a_r11_sequential_wait: assert property (@(posedge clk) disable iff (!rst_n)
        (!nest_q && depth != '0) |-> !irq_valid);

    a_r12_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        stk_ovf |=> stk_ovf);

    a_r12_drain_empty: assert property (@(posedge clk) disable iff (!rst_n)
        (rti && !ack && depth == DEPTH_W'(1)) |=> stk_empty);

    a_r12_depth_bound: assert property (@(posedge clk) disable iff (!rst_n)
        depth <= DEPTH_W'(STACK_DEPTH));
endmodule

bind irqc_top irqc_checker #(
    .STACK_DEPTH (STACK_DEPTH),
    .DEPTH_W     (DEPTH_W)
) u_irqc_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .mask_wr   (mask_wr),
    .gie_off   (gie_off),
    .ack       (ack),
    .rti       (rti),
    .nest_q    (nest_q),
    .mask_q    (mask_q),
    .irq_valid (irq_valid),
    .irq_idx   (irq_idx),
    .irq_vec   (irq_vec),
    .depth     (depth),
    .stk_empty (stk_empty),
    .stk_ovf   (stk_ovf)
);

// File: tb/test_irqc_top.sv
module test_irqc_top;
    localparam int DEPTH = 4;
    localparam int DW    = $clog2(DEPTH + 1);

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic        rst_n;
    logic [2:0]  ext_n;
    logic        pwd_req, host_wr_req, host_rd_req, sp0_tx_req, sp0_rx_req;
    logic        sp1_tx_req, sp1_rx_req, tmr_req;
    logic        mask_wr, ctl_wr, fc_wr, gie_on, gie_off, ack, rti;
    logic [10:0] mask_data, fc_set, fc_clr;
    logic [3:0]  ctl_data;
    logic        irq_valid;
    logic [3:0]  irq_idx;
    logic [13:0] irq_vec;
    logic [DW-1:0] depth;
    logic        stk_empty, stk_ovf;

    irqc_top #(.STACK_DEPTH(DEPTH)) i_irqc_top (
        .clk(clk), .rst_n(rst_n), .ext_n(ext_n),
        .pwd_req(pwd_req), .host_wr_req(host_wr_req), .host_rd_req(host_rd_req),
        .sp0_tx_req(sp0_tx_req), .sp0_rx_req(sp0_rx_req),
        .sp1_tx_req(sp1_tx_req), .sp1_rx_req(sp1_rx_req), .tmr_req(tmr_req),
        .mask_wr(mask_wr), .mask_data(mask_data), .ctl_wr(ctl_wr), .ctl_data(ctl_data),
        .fc_wr(fc_wr), .fc_set(fc_set), .fc_clr(fc_clr),
        .gie_on(gie_on), .gie_off(gie_off), .ack(ack), .rti(rti),
        .irq_valid(irq_valid), .irq_idx(irq_idx), .irq_vec(irq_vec),
        .depth(depth), .stk_empty(stk_empty), .stk_ovf(stk_ovf)
    );

    int n_chk  = 0;
    int n_fail = 0;

    // {mask, forced pending, expected valid, expected index}
    localparam logic [26:0] TBL [9] = '{
        {11'h7FF, 11'h7FF, 1'b1, 4'd0},
        {11'h000, 11'h001, 1'b1, 4'd0},
        {11'h000, 11'h7FE, 1'b0, 4'd0},
        {11'h400, 11'h7FE, 1'b1, 4'd10},
        {11'h7FE, 11'h500, 1'b1, 4'd8},
        {11'h0C0, 11'h0C0, 1'b1, 4'd6},
        {11'h001, 11'h004, 1'b0, 4'd0},
        {11'h7FF, 11'h018, 1'b1, 4'd3},
        {11'h006, 11'h006, 1'b1, 4'd1}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic check_out(input string req, input logic v, input int idx);
        check({req, " valid"}, 32'(irq_valid), 32'(v));
        if (v) begin
            check({req, " index"}, 32'(irq_idx), 32'(idx));
            check({req, " vector"}, 32'(irq_vec), (idx == 0) ? 32'h2C : 32'(idx * 4));
        end
    endtask

    task automatic tick;
        @(negedge clk);
    endtask

    task automatic idle;
        pwd_req = 0; host_wr_req = 0; host_rd_req = 0; sp0_tx_req = 0; sp0_rx_req = 0;
        sp1_tx_req = 0; sp1_rx_req = 0; tmr_req = 0;
        mask_wr = 0; ctl_wr = 0; fc_wr = 0; gie_on = 0; gie_off = 0; ack = 0; rti = 0;
        fc_set = '0; fc_clr = '0;
    endtask

    task automatic force_bits(input logic [10:0] s);
        fc_wr = 1; fc_set = s; tick; idle;
    endtask

    task automatic clear_all;
        fc_wr = 1; fc_clr = '1; tick; idle;
    endtask

    task automatic summary;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        summary;
        $finish;
    end

    initial begin
        rst_n = 0; ext_n = 3'b111; mask_data = '0; ctl_data = '0;
        idle;
        repeat (3) tick;
        rst_n = 1;
        tick;
        // R3 reset state
        check_out("R3 reset", 1'b0, 0);
        check("R3 depth", 32'(depth), 0);
        check("R3 empty", 32'(stk_empty), 1);
        check("R3 ovf", 32'(stk_ovf), 0);
        force_bits(11'h400);
        check_out("R3 mask cleared", 1'b0, 0);
        force_bits(11'h001);
        check_out("R3 global enabled", 1'b1, 0);
        clear_all;

        // R1 R2 priority and mask table
        for (int k = 0; k < 9; k++) begin
            mask_wr = 1; mask_data = TBL[k][26:16]; fc_wr = 1; fc_clr = '1; tick; idle;
            force_bits(TBL[k][15:5]);
            check_out("R1 R2 table", TBL[k][4], int'(TBL[k][3:0]));
        end
        clear_all;

        // R6 hold after mask write
        mask_wr = 1; mask_data = '0; tick; idle;
        force_bits(11'h020);
        mask_wr = 1; mask_data = 11'h7FF; tick; idle;
        check_out("R6 settle cycle", 1'b0, 0);
        tick;
        check_out("R6 after settle", 1'b1, 5);

        // R7 global disable blocks powerdown
        pwd_req = 1; tick; idle;
        gie_off = 1; tick; idle;
        check_out("R7 shut", 1'b0, 0);
        tick;
        check_out("R7 still shut", 1'b0, 0);
        gie_on = 1; tick; idle;
        check_out("R7 reopened", 1'b1, 0);

        // R8 force/clear
        fc_wr = 1; fc_clr = 11'h021; tick; idle;
        check_out("R8 cleared", 1'b0, 0);
        fc_wr = 1; fc_set = 11'h080; fc_clr = 11'h080; tick; idle;
        check_out("R8 clear wins", 1'b0, 0);

        // R4 edge mode on pin 2, sequential
        ctl_wr = 1; ctl_data = 4'b0100; tick; idle;
        ext_n[2] = 0; tick;
        check_out("R4 not yet", 1'b0, 0);
        tick;
        check_out("R4 edge latched", 1'b1, 1);
        ext_n[2] = 1; tick;
        check_out("R4 held after release", 1'b1, 1);

        // R9 acknowledge, R11 sequential wait
        ack = 1; tick; idle;
        check_out("R11 blocked in service", 1'b0, 0);
        check("R9 depth", 32'(depth), 1);
        check("R12 not empty", 32'(stk_empty), 0);
        pwd_req = 1; tick; idle;
        check_out("R11 higher still waits", 1'b0, 0);
        rti = 1; tick; idle;
        check("R12 depth back", 32'(depth), 0);
        check("R12 empty", 32'(stk_empty), 1);
        check_out("R11 after return", 1'b1, 0);
        fc_wr = 1; fc_clr = 11'h001; tick; idle;
        check_out("R9 ack cleared latch", 1'b0, 0);

        // R5 level mode on pin 0
        ctl_wr = 1; ctl_data = 4'b0000; tick; idle;
        ext_n[0] = 0; tick;
        check_out("R5 level seen", 1'b1, 9);
        ack = 1; tick; idle;
        rti = 1; tick; idle;
        check_out("R5 ack no effect", 1'b1, 9);
        ext_n[0] = 1; tick;
        check_out("R5 release", 1'b0, 0);

        // R10 nested mode
        ctl_wr = 1; ctl_data = 4'b1000; tick; idle;
        force_bits(11'h020);
        ack = 1; tick; idle;
        force_bits(11'h080);
        check_out("R10 lower blocked", 1'b0, 0);
        force_bits(11'h004);
        check_out("R10 higher preempts", 1'b1, 2);
        ack = 1; tick; idle;
        check_out("R10 two in service", 1'b0, 0);
        rti = 1; tick; idle;
        check("R10 depth one", 32'(depth), 1);
        check_out("R10 outer still blocks", 1'b0, 0);
        rti = 1; tick; idle;
        check_out("R10 released", 1'b1, 7);
        clear_all;

        // R12 overflow with small stack
        for (int k = 10; k >= 7; k--) begin
            force_bits(11'(1) << k);
            ack = 1; tick; idle;
        end
        check("R12 full depth", 32'(depth), DEPTH);
        check("R12 no ovf yet", 32'(stk_ovf), 0);
        force_bits(11'h040);
        check_out("R12 fifth nest", 1'b1, 6);
        ack = 1; tick; idle;
        check("R12 ovf set", 32'(stk_ovf), 1);
        check("R12 saturated", 32'(depth), DEPTH);
        for (int k = 0; k < 5; k++) begin
            rti = 1; tick; idle;
        end
        check("R12 drained", 32'(depth), 0);
        check("R12 empty after drain", 32'(stk_empty), 1);
        check("R12 ovf sticky", 32'(stk_ovf), 1);

        summary;
        $finish;
    end
endmodule